// File: doc/BRIEF.md
# Prescaled Interval Timer with Output Pin

This block is a memory-mapped interval timer for setting a sampling rate. A free-running prescaler divides the system clock by four to make a count tick. On every tick a counter steps up by one. When the stepped value reaches the programmed period, the counter returns to zero, a one-clock event pulse is raised, and the output pin state is updated.

The output pin works in one of two ways. In clock mode the pin toggles on every match, so one full pin cycle spans two periods. In pulse mode the pin goes active for one tick after each match. Software uses a small read/write register bus to program a period, set control bits and then start the timer with a go bit. It can also read or overwrite the live count at any time.

Top module: `interval_timer`

## Requirements
- R1: After reset the control, period and counter registers read 0, `tmr_out` is 0 and `tmr_event` is 0.
- R2: Byte offset 0x0 selects control, 0x4 selects period and 0x8 selects counter. Written values read back through `bus_rdata` while `bus_sel`=1 and `bus_we`=0. Any other offset reads 0, and control bit 6 always reads 0.
- R3: The counter advances only while control bit 7 (run) is 1. With bit 7 at 0 the counter keeps its value.
- R4: While running, a tick occurs every 4 clocks. On each tick the counter becomes count+1. If count+1 is greater than or equal to the period P, the counter becomes 0 instead and a match occurs, so matches come every 4·P clocks when P≥1.
- R5: Each match produces a `tmr_event` pulse that is exactly one clock wide. The pulse occurs whatever the pin enable (control bit 0) is set to.
- R6: Writing control with bit 6 (go) set clears the counter, the prescaler and the pin state. Counting then starts from there, and the first event shows 4·P clocks after the write edge. The go bit does not stay set.
- R7: With control bit 8 = 1 (clock mode), the pin state toggles on every match. The pin is high for 4·P clocks and low for 4·P clocks.
- R8: With control bit 8 = 0 (pulse mode), the pin state is 1 for exactly 4 clocks (one tick) after each match, for P≥2.
- R9: `tmr_out` equals the pin state XOR control bit 2 (polarity) while control bit 0 is 1. While control bit 0 is 0, `tmr_out` is held at 0.
- R10: A write to the counter register takes effect at that clock edge. If a tick falls on the same edge, the write takes priority: the count is not incremented and no match occurs on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; combinational, valid during a read strobe |
| tmr_out | output | 1 | Timer output pin |
| tmr_event | output | 1 | One-clock pulse on each period match |

## Verification
A software write to the counter can land on the same clock edge as a prescaler tick, so the two compete to update the count. The bench starts the timer with go, waits three clocks and writes a count of P−1 so that the write lands exactly on the first tick edge. If the write wins, the next event must follow four clocks later. If the tick increment wins, or both take effect, the event comes late.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int DW       = 32,
  parameter int PRESCALE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [3:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tmr_out,
  output logic          tmr_event
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_PRD  = 4'h4;
  localparam logic [3:0] OFS_CNT  = 4'h8;
  localparam logic [PW-1:0] DIV_LAST = PW'(PRESCALE - 1);

  logic [DW-1:0] period_q, cnt_q;
  logic [PW-1:0] div_q;
  logic out_en_q, inv_q, run_q, clk_mode_q, state_q, event_q;

  logic wr, wr_ctrl, wr_prd, wr_cnt, go, tick, match;
  logic [DW-1:0] cnt_inc;

  assign wr      = bus_sel & bus_we;
  assign wr_ctrl = wr && bus_addr == OFS_CTRL;
  assign wr_prd  = wr && bus_addr == OFS_PRD;
  assign wr_cnt  = wr && bus_addr == OFS_CNT;
  assign go      = wr_ctrl && bus_wdata[6];
  assign tick    = run_q && div_q == DIV_LAST;
  assign cnt_inc = cnt_q + 1'b1;
  assign match   = tick && !wr_cnt && !go && cnt_inc >= period_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_en_q <= 1'b0; inv_q <= 1'b0; run_q <= 1'b0; clk_mode_q <= 1'b0;
    end else if (wr_ctrl) begin
      out_en_q   <= bus_wdata[0];
      inv_q      <= bus_wdata[2];
      run_q      <= bus_wdata[7];
      clk_mode_q <= bus_wdata[8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      period_q <= '0;
    else if (wr_prd) period_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_q <= '0;
    else if (go)    div_q <= '0;
    else if (run_q) div_q <= tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (go)     cnt_q <= '0;
    else if (wr_cnt) cnt_q <= bus_wdata;
    else if (tick)   cnt_q <= match ? '0 : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    state_q <= 1'b0;
    else if (go)                   state_q <= 1'b0;
    else if (match)                state_q <= clk_mode_q ? ~state_q : 1'b1;
    else if (tick && !clk_mode_q)  state_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) event_q <= 1'b0;
    else        event_q <= match;
  end

  assign tmr_event = event_q;
  assign tmr_out   = out_en_q & (state_q ^ inv_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        OFS_CTRL: begin
          bus_rdata[0] = out_en_q;
          bus_rdata[2] = inv_q;
          bus_rdata[7] = run_q;
          bus_rdata[8] = clk_mode_q;
        end
        OFS_PRD: bus_rdata = period_q;
        OFS_CNT: bus_rdata = cnt_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_event |=> !tmr_event); // R5
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_cnt && !go) |=> $stable(cnt_q)); // R3
  AST_GO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (cnt_q == '0 && !tmr_event)); // R6
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !go) |=> (cnt_q == $past(bus_wdata) && !tmr_event)); // R10
  AST_CLOCK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_event && clk_mode_q && $past(clk_mode_q) && $past(!go)) |-> state_q != $past(state_q)); // R7
endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tmr_out, tmr_event;
  int checks = 0, errors = 0;
  logic [31:0] rd;
  int n;

  always #2.5 clk = ~clk;

  interval_timer u_dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_out(tmr_out), .tmr_event(tmr_event));

  localparam int NV = 6;
  localparam int VP[NV]    = '{3, 5, 2, 7, 1, 4};
  localparam int VMODE[NV] = '{1, 1, 0, 0, 1, 1};
  localparam int VGAP[NV]  = '{12, 20, 8, 28, 4, 16};
  localparam int VHIGH[NV] = '{12, 20, 4, 4, 4, 16};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic cycles_to_event(output int c);
    c = 0;
    do begin @(negedge clk); c++; end while (!tmr_event && c < 2000);
  endtask

  task automatic high_width(output int c);
    int g = 0;
    logic prev = tmr_out;
    while (!(tmr_out && !prev) && g < 2000) begin prev = tmr_out; @(negedge clk); g++; end
    c = 0;
    while (tmr_out && c < 2000) begin @(negedge clk); c++; end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rdreg(4'h0, rd); check("R1 ctrl", rd, 0);
    rdreg(4'h4, rd); check("R1 period", rd, 0);
    rdreg(4'h8, rd); check("R1 counter", rd, 0);
    check("R1 out", tmr_out, 0);
    check("R1 event", tmr_event, 0);

    for (int i = 0; i < NV; i++) begin
      wr(4'h4, VP[i]);
      wr(4'h0, VMODE[i] ? 32'h1C1 : 32'h0C1);
      cycles_to_event(n); check("R6 first event", n, VGAP[i]);
      cycles_to_event(n); check("R4 event gap", n, VGAP[i]);
      high_width(n); check(VMODE[i] ? "R7 clock high" : "R8 pulse high", n, VHIGH[i]);
    end

    wr(4'h0, 32'h0);
    wr(4'h4, 32'h1234); rdreg(4'h4, rd); check("R2 period rb", rd, 32'h1234);
    wr(4'h8, 32'h55);   rdreg(4'h8, rd); check("R10 counter write", rd, 32'h55);
    repeat (40) @(negedge clk);
    rdreg(4'h8, rd); check("R3 hold freeze", rd, 32'h55);
    rdreg(4'hC, rd); check("R2 unmapped", rd, 0);
    wr(4'h0, 32'h1C5); rdreg(4'h0, rd); check("R2 go reads 0", rd, 32'h185);

    wr(4'h4, 32'd3);
    wr(4'h0, 32'h0C4);
    n = 0;
    repeat (40) begin @(negedge clk); if (tmr_out) n++; end
    check("R9 disabled pin low", n, 0);
    cycles_to_event(n); check("R5 event when pin off", n < 13, 1);
    wr(4'h0, 32'h0C5);
    @(negedge clk); check("R9 inverted idle", tmr_out, 1);
    cycles_to_event(n); @(negedge clk); check("R9 inverted active", tmr_out, 0);

    wr(4'h4, 32'd10);
    wr(4'h0, 32'h0C1);
    repeat (3) @(negedge clk);
    wr(4'h8, 32'd9);
    cycles_to_event(n); check("R10 write beats tick", n, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule